// File: doc/BRIEF.md
# Bulk Command Stream Register Decoder

This block sits behind a host link and consumes a byte stream of bulk commands. It finds each command by its marker byte and reads the command code after it. Register-write commands are applied to a small 8-bit-addressed register file that holds the video configuration. Pixel-copy commands are recognised and skipped over by their fixed payload length. Any other command code raises a sticky error flag.

Timing updates can be grouped into one atomic change. A write of the lock value to the control address makes every later write land only in shadow storage. A write of the unlock value copies the whole shadow set into the active registers in one cycle and pulses a commit strobe.

The active registers are visible in two ways: through a combinational read port, and as decoded multi-byte fields. Some of these fields are stored high byte first and one is stored low byte first.

The input is a valid/ready byte stream. A byte is taken on every rising clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low during reset and high from the first clock edge after reset. The decoder therefore never applies back-pressure, and a sender may present one byte per cycle without stalling.

Top module: `bulk_reg_decoder`

## Requirements
- R1: After reset all registers read 0, `locked`, `commit` and `err` are 0, and `s_ready` is 1 from the first clock edge after reset onward.
- R2: The sequence 0xAF, 0x20, address, value updates the active register at that address when unlocked. The value is readable on `rd_data` within three cycles of the value byte.
- R3: A byte other than 0xAF, arriving where a command start is expected, is dropped without effect. Decoding resumes at the next 0xAF.
- R4: A marker that is directly followed by another marker is absorbed. The second marker starts the command.
- R5: Code 0x6A (copy) causes exactly the next 7 bytes to be skipped, whatever their values, including 0xAF. No register changes.
- R6: Any code other than 0x20, 0x6A or 0xAF sets `err`, which stays set until reset. The decoder returns to waiting for a marker.
- R7: Writing 0x01 to control address 0x3F sets `locked`. While locked, writes leave the active registers and fields unchanged. Writing any value other than 0x01 or 0x00 to 0x3F has no effect. Reading 0x3F returns `locked` in bit 0.
- R8: Writing 0x00 to 0x3F while locked moves every staged value to the active registers in the same cycle, clears `locked`, and pulses `commit` for exactly one cycle. Writing 0x00 while unlocked pulses nothing.
- R9: `pix_clk` takes its low byte from address 0x1B and its high byte from 0x1C.
- R10: `base16` is formed from addresses 0x20, 0x21, 0x22, and `base8` from 0x26, 0x27, 0x28. In each case the lowest address holds the most significant byte.
- R11: `h_active` takes its high byte from 0x0F and its low byte from 0x10.
- R12: Writes to addresses of 64 or more are ignored and change no register. Reads at those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Decoder can take a byte |
| s_data | input | 8 | Input byte |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Active register at `rd_addr` (combinational) |
| h_active | output | 16 | Active width field, high byte first |
| pix_clk | output | 16 | Pixel clock field, low byte first |
| base16 | output | 24 | 16bpp segment base pointer |
| base8 | output | 24 | 8bpp segment base pointer |
| locked | output | 1 | Shadow staging in force |
| commit | output | 1 | One-cycle pulse when staged values go live |
| err | output | 1 | Sticky unknown-command flag |

## Verification
The assertions assume that reset is applied before any byte is offered. They also assume that `s_data` is a defined value whenever `s_valid` is high. No assumption is made about write spacing: every write needs four bytes, so the parser's write pulses can never be adjacent. The directed stimulus drives bytes only after reset, with `s_valid` low between commands and clean byte values. It brackets staged writes with lock and unlock values so that every commit strobe comes from a real unlock.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam logic [7:0] MARK       = 8'hAF;
  localparam logic [7:0] CODE_WR    = 8'h20;
  localparam logic [7:0] CODE_COPY  = 8'h6A;
  localparam int         COPY_LEN   = 7;

  localparam int F_HACT   = 8'h0F;
  localparam int F_PCLK   = 8'h1B;
  localparam int F_BASE16 = 8'h20;
  localparam int F_BASE8  = 8'h26;

  typedef enum logic [2:0] {
    S_IDLE, S_CODE, S_ADDR, S_DATA, S_SKIP
  } pstate_t;
endpackage

// File: rtl/bsd_parser.sv
module bsd_parser
  import bsd_pkg::*;
#(
  parameter int SKIP_LEN = COPY_LEN
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       err
);
  localparam int CW = $clog2(SKIP_LEN + 1);

  pstate_t       st;
  logic [CW-1:0] cnt;
  logic          take;

  assign take = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      in_ready <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      err      <= 1'b0;
      cnt      <= '0;
    end else begin
      in_ready <= 1'b1;
      wr_en    <= 1'b0;
      if (take) begin
        case (st)
          S_IDLE: if (in_data == MARK) st <= S_CODE;
          S_CODE: begin
            if (in_data == MARK) begin
              st <= S_CODE;
            end else if (in_data == CODE_WR) begin
              st <= S_ADDR;
            end else if (in_data == CODE_COPY) begin
              st  <= S_SKIP;
              cnt <= CW'(SKIP_LEN - 1);
            end else begin
              err <= 1'b1;
              st  <= S_IDLE;
            end
          end
          S_ADDR: begin
            wr_addr <= in_data;
            st      <= S_DATA;
          end
          S_DATA: begin
            wr_data <= in_data;
            wr_en   <= 1'b1;
            st      <= S_IDLE;
          end
          S_SKIP: begin
            if (cnt == '0) st <= S_IDLE;
            else           cnt <= cnt - 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R2: a write takes four bytes, so write pulses never touch
  a_r2_wr_spaced: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  // R6: error flag holds until reset
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R5: skipped payload never produces a write
  a_r5_skip_no_write: assert property (@(posedge clk) disable iff (rst)
    (st == S_SKIP) |=> !wr_en);
endmodule

// File: rtl/bsd_regfile.sv
module bsd_regfile #(
  parameter int         DEPTH      = 64,
  parameter int         CTRL_ADDR  = 8'h3F,
  parameter logic [7:0] LOCK_VAL   = 8'h01,
  parameter logic [7:0] UNLOCK_VAL = 8'h00
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  output logic [DEPTH-1:0][7:0] act,
  output logic                  locked,
  output logic                  commit
);
  logic ctrl_hit, do_lock, do_unlock;

  assign ctrl_hit  = wr_en && (wr_addr == 8'(CTRL_ADDR));
  assign do_lock   = ctrl_hit && (wr_data == LOCK_VAL);
  assign do_unlock = ctrl_hit && (wr_data == UNLOCK_VAL) && locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      commit <= 1'b0;
    end else begin
      commit <= do_unlock;
      if (do_lock)        locked <= 1'b1;
      else if (do_unlock) locked <= 1'b0;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    if (i == CTRL_ADDR) begin : g_ctrl
      assign act[i] = 8'h00;
    end else begin : g_data
      logic [7:0] shd_q, act_q;
      logic       hit;
      assign hit = wr_en && (wr_addr == 8'(i));
      always_ff @(posedge clk) begin
        if (rst) begin
          shd_q <= '0;
          act_q <= '0;
        end else begin
          if (hit) shd_q <= wr_data;
          if (do_unlock)         act_q <= shd_q;
          else if (hit && !locked) act_q <= wr_data;
        end
      end
      assign act[i] = act_q;
    end
  end

  // R8: commit is a single-cycle strobe
  a_r8_commit_pulse: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);
  // R8: commit leaves the block unlocked
  a_r8_commit_unlocks: assert property (@(posedge clk) disable iff (rst)
    commit |-> !locked);
  // R7: while locked, the active set only moves on a commit
  a_r7_locked_hold: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(act) || commit));
endmodule

// File: rtl/bsd_field.sv
module bsd_field #(
  parameter int NB        = 2,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic [NB-1:0][7:0] bytes,
  output logic [8*NB-1:0]    val
);
  for (genvar k = 0; k < NB; k++) begin : g_b
    if (MSB_FIRST) begin : g_be
      assign val[8*(NB-1-k) +: 8] = bytes[k];
    end else begin : g_le
      assign val[8*k +: 8] = bytes[k];
    end
  end
endmodule

// File: rtl/bulk_reg_decoder.sv
module bulk_reg_decoder
  import bsd_pkg::*;
#(
  parameter int         DEPTH      = 64,
  parameter int         CTRL_ADDR  = 8'h3F,
  parameter logic [7:0] LOCK_VAL   = 8'h01,
  parameter logic [7:0] UNLOCK_VAL = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic [7:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic [15:0] h_active,
  output logic [15:0] pix_clk,
  output logic [23:0] base16,
  output logic [23:0] base8,
  output logic        locked,
  output logic        commit,
  output logic        err
);
  localparam int IW = $clog2(DEPTH);

  logic                  wr_en;
  logic [7:0]            wr_addr, wr_data;
  logic [DEPTH-1:0][7:0] act;

  bsd_parser #(.SKIP_LEN(COPY_LEN)) u_parse (
    .clk(clk), .rst(rst),
    .in_valid(s_valid), .in_data(s_data), .in_ready(s_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .err(err)
  );

  bsd_regfile #(
    .DEPTH(DEPTH), .CTRL_ADDR(CTRL_ADDR),
    .LOCK_VAL(LOCK_VAL), .UNLOCK_VAL(UNLOCK_VAL)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .act(act), .locked(locked), .commit(commit)
  );

  always_comb begin
    if (rd_addr == 8'(CTRL_ADDR))    rd_data = {7'b0, locked};
    else if (32'(rd_addr) < DEPTH)   rd_data = act[rd_addr[IW-1:0]];
    else                             rd_data = 8'h00;
  end

  bsd_field #(.NB(2), .MSB_FIRST(1'b1)) u_hact (
    .bytes(act[F_HACT+1:F_HACT]), .val(h_active));
  bsd_field #(.NB(2), .MSB_FIRST(1'b0)) u_pclk (
    .bytes(act[F_PCLK+1:F_PCLK]), .val(pix_clk));
  bsd_field #(.NB(3), .MSB_FIRST(1'b1)) u_b16 (
    .bytes(act[F_BASE16+2:F_BASE16]), .val(base16));
  bsd_field #(.NB(3), .MSB_FIRST(1'b1)) u_b8 (
    .bytes(act[F_BASE8+2:F_BASE8]), .val(base8));
endmodule

// File: tb/tb_bulk_reg_decoder.sv
`timescale 1ns/1ps
module tb_bulk_reg_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        s_valid;
  logic        s_ready;
  logic [7:0]  s_data;
  logic [7:0]  rd_addr;
  logic [7:0]  rd_data;
  logic [15:0] h_active, pix_clk;
  logic [23:0] base16, base8;
  logic        locked, commit, err;

  int checks = 0;
  int fails  = 0;
  int commits = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bulk_reg_decoder dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .h_active(h_active), .pix_clk(pix_clk),
    .base16(base16), .base8(base8), .locked(locked), .commit(commit), .err(err)
  );

  always @(posedge clk) if (!rst && commit) commits <= commits + 1;

  task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  task automatic put(logic [7:0] b);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = b;
    @(posedge clk);
    #1;
    chk("R1 ready while streaming", 32'(s_ready), 32'd1);
    s_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    put(8'hAF); put(8'h20); put(a); put(d);
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp_v);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(req, 32'(rd_data), 32'(exp_v));
  endtask

  task automatic t_reset();
    rd_chk("R1 reg reset", 8'h20, 8'h00);
    rd_chk("R1 ctrl reset", 8'h3F, 8'h00);
    chk("R1 locked", 32'(locked), 0);
    chk("R1 commit", 32'(commit), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 ready", 32'(s_ready), 1);
  endtask

  task automatic t_write();
    wr(8'h05, 8'h5A); settle();
    rd_chk("R2 write", 8'h05, 8'h5A);
  endtask

  task automatic t_junk();
    put(8'h11); put(8'h22); put(8'h20);
    wr(8'h06, 8'h77); settle();
    rd_chk("R3 resync", 8'h06, 8'h77);
    chk("R3 no err", 32'(err), 0);
  endtask

  task automatic t_dbl_marker();
    put(8'hAF);
    wr(8'h07, 8'h33); settle();
    rd_chk("R4 double marker", 8'h07, 8'h33);
  endtask

  task automatic t_copy();
    put(8'hAF); put(8'h6A);
    put(8'hAF); put(8'h20); put(8'h08); put(8'h99);
    put(8'hAF); put(8'h20); put(8'h08);
    wr(8'h09, 8'h44); settle();
    rd_chk("R5 payload skipped", 8'h08, 8'h00);
    rd_chk("R5 next command", 8'h09, 8'h44);
    chk("R5 no err", 32'(err), 0);
  endtask

  task automatic t_unknown();
    put(8'hAF); put(8'h55);
    put(8'h20); put(8'h0A); put(8'h12);
    settle();
    chk("R6 err set", 32'(err), 1);
    wr(8'h0B, 8'h66); settle();
    rd_chk("R6 no stray write", 8'h0A, 8'h00);
    rd_chk("R6 resumes", 8'h0B, 8'h66);
    chk("R6 err sticky", 32'(err), 1);
  endtask

  task automatic t_lock_commit();
    int c0;
    wr(8'h3F, 8'h01); settle();
    chk("R7 locked", 32'(locked), 1);
    rd_chk("R7 ctrl read", 8'h3F, 8'h01);
    wr(8'h1B, 8'h10); wr(8'h1C, 8'h27); wr(8'h05, 8'hC3);
    wr(8'h3F, 8'h42); settle();
    chk("R7 pix_clk held", 32'(pix_clk), 0);
    rd_chk("R7 reg held", 8'h05, 8'h5A);
    chk("R7 other ctrl value", 32'(locked), 1);
    c0 = commits;
    wr(8'h3F, 8'h00); settle();
    chk("R8 one commit", 32'(commits), 32'(c0 + 1));
    chk("R8 unlocked", 32'(locked), 0);
    chk("R9 pix_clk low first", 32'(pix_clk), 32'h2710);
    rd_chk("R8 staged reg live", 8'h05, 8'hC3);
    wr(8'h3F, 8'h00); settle();
    chk("R8 no commit unlocked", 32'(commits), 32'(c0 + 1));
  endtask

  task automatic t_fields();
    wr(8'h0F, 8'h05); wr(8'h10, 8'h00);
    wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
    wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF);
    settle();
    chk("R11 h_active", 32'(h_active), 32'h0500);
    chk("R10 base16", 32'(base16), 32'h123456);
    chk("R10 base8", 32'(base8), 32'hABCDEF);
  endtask

  task automatic t_range();
    wr(8'h50, 8'h99); wr(8'hFF, 8'h77); settle();
    rd_chk("R12 read out of range", 8'h50, 8'h00);
    rd_chk("R12 no alias", 8'h10, 8'h00);
    rd_chk("R12 no alias hi", 8'h3F, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; s_valid = 1'b0; s_data = 8'h00; rd_addr = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_junk();
    t_dbl_marker();
    t_copy();
    t_unknown();
    t_lock_commit();
    t_fields();
    t_range();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule